// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table kept in ordinary memory. A requester hands it an address with two flags: whether the access is a write and whether it comes from user code. The walker reads the top-level entry, then the leaf entry, and checks the leaf's flags. It answers with the physical address or a fault code. Only one walk is in progress at a time. Both request and response use a valid/ready handshake.

The walker reaches memory through a single port. The port issues a read or write with a valid/ready handshake. A read returns one data beat after any number of cycles. When a permitted write hits a leaf whose dirty flag is still clear, the walker stores the leaf back with that flag set. The response is not given until that store has been accepted. The top-level table base comes from the `root_base` input, which is captured when a request is taken.

Top module: `ptw_top`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. `req_ready` is 1 only while no walk is in progress. A raised `rsp_valid` holds, with `rsp_paddr` and `rsp_status` unchanged, until `rsp_ready` is seen.
- R2: The first memory read of a walk is at `root_base + 4*vaddr[31:22]`.
- R3: The second read is at `{L1[31:12], 12'h000} + 4*vaddr[21:12]`, where L1 is the top-level entry.
- R4: If the top-level entry has bit 0 (present) clear, the walk ends after that single read with `rsp_status` 1 (not present) and `rsp_paddr` 0.
- R5: If the leaf entry has bit 0 clear, `rsp_status` is 1, whatever its other flags hold.
- R6: A write access to a present leaf with bit 1 (writable) clear gives `rsp_status` 2 (protection), and no memory write is made.
- R7: A user access to a present leaf with bit 2 (user) clear gives `rsp_status` 2. A non-user access to the same leaf succeeds.
- R8: On success `rsp_status` is 0 and `rsp_paddr` is `{leaf[31:12], vaddr[11:0]}`.
- R9: A permitted write to a leaf with bit 6 (dirty) clear makes exactly one memory write. The write goes to the leaf's address, carries the leaf value with bit 6 set, and is accepted before the response is raised.
- R10: Reads, faulting walks, and writes to a leaf whose dirty bit is already set make no memory write.
- R11: A memory request holds `mem_req_valid`, `mem_addr` and `mem_we` stable until `mem_req_ready`. Walk results do not depend on stall or read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Byte address of the top-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user code |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_status | output | 2 | 0 ok, 1 not present, 2 protection |
| mem_req_valid | output | 1 | Table memory access valid |
| mem_req_ready | input | 1 | Memory takes the access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Entry value to store |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench builds the walker with its default split of 10, 10 and 12 bits and 4-byte entries. This means real table addresses appear on the memory port and can be predicted by hand, including the last index of both tables. The bench's memory model switches between an always-ready, one-cycle-latency setting and one that stalls two of every three cycles and returns data after four cycles. This brings the request-hold and response-hold behaviour within reach, next to the fault orderings and dirty write-back.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_WB_REQ  = 3'd5,
        ST_RESP    = 3'd6
    } walk_state_e;

    typedef enum logic [1:0] {
        WALK_OK          = 2'd0,
        WALK_NOT_PRESENT = 2'd1,
        WALK_PROTECT     = 2'd2
    } walk_status_e;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 10,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);

    always_comb begin
        entry_addr = table_base + (ADDR_W'(index) << SHIFT);
    end
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
    import ptw_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int P_BIT = 0,
    parameter int W_BIT = 1,
    parameter int U_BIT = 2,
    parameter int D_BIT = 6
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    input  logic             is_user,
    output walk_status_e     status,
    output logic             need_dirty
);
    always_comb begin
        status = WALK_OK;
        if (!pte[P_BIT]) begin
            status = WALK_NOT_PRESENT;
        end else if ((is_write && !pte[W_BIT]) || (is_user && !pte[U_BIT])) begin
            status = WALK_PROTECT;
        end
        need_dirty = (status == WALK_OK) && is_write && !pte[D_BIT];
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int L1_IDX_W  = 10,
    parameter int L2_IDX_W  = 10,
    parameter int OFF_W     = 12,
    parameter int PTE_BYTES = 4,
    parameter int P_BIT     = 0,
    parameter int W_BIT     = 1,
    parameter int U_BIT     = 2,
    parameter int D_BIT     = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PA_W-1:0] root_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    input  logic            req_user,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [PA_W-1:0] rsp_paddr,
    output logic [1:0]      rsp_status,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_we,
    output logic [PA_W-1:0] mem_addr,
    output logic [PA_W-1:0] mem_wdata,
    input  logic            mem_rsp_valid,
    input  logic [PA_W-1:0] mem_rdata
);
    localparam int BASE_W = PA_W - OFF_W;
    localparam int L2_LO  = OFF_W;
    localparam int L1_LO  = OFF_W + L2_IDX_W;

    typedef struct packed {
        walk_state_e       st;
        logic [VA_W-1:0]   vaddr;
        logic              is_write;
        logic              is_user;
        logic [PA_W-1:0]   root;
        logic [BASE_W-1:0] base;
        logic [PA_W-1:0]   leaf;
        logic [PA_W-1:0]   paddr;
        walk_status_e      status;
    } walk_t;

    walk_t q, d;

    logic [PA_W-1:0] l1_addr;
    logic [PA_W-1:0] l2_addr;
    walk_status_e    leaf_status;
    logic            leaf_need_dirty;

    ptw_entry_addr #(
        .ADDR_W      (PA_W),
        .IDX_W       (L1_IDX_W),
        .ENTRY_BYTES (PTE_BYTES)
    ) u_l1_addr (
        .table_base (q.root),
        .index      (q.vaddr[L1_LO +: L1_IDX_W]),
        .entry_addr (l1_addr)
    );

    ptw_entry_addr #(
        .ADDR_W      (PA_W),
        .IDX_W       (L2_IDX_W),
        .ENTRY_BYTES (PTE_BYTES)
    ) u_l2_addr (
        .table_base ({q.base, {OFF_W{1'b0}}}),
        .index      (q.vaddr[L2_LO +: L2_IDX_W]),
        .entry_addr (l2_addr)
    );

    ptw_leaf_check #(
        .PTE_W (PA_W),
        .P_BIT (P_BIT),
        .W_BIT (W_BIT),
        .U_BIT (U_BIT),
        .D_BIT (D_BIT)
    ) u_leaf_check (
        .pte        (mem_rdata),
        .is_write   (q.is_write),
        .is_user    (q.is_user),
        .status     (leaf_status),
        .need_dirty (leaf_need_dirty)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.vaddr    = req_vaddr;
                    d.is_write = req_write;
                    d.is_user  = req_user;
                    d.root     = root_base;
                    d.st       = ST_L1_REQ;
                end
            end
            ST_L1_REQ: begin
                if (mem_req_ready) d.st = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!mem_rdata[P_BIT]) begin
                        d.status = WALK_NOT_PRESENT;
                        d.paddr  = '0;
                        d.st     = ST_RESP;
                    end else begin
                        d.base = mem_rdata[PA_W-1:OFF_W];
                        d.st   = ST_L2_REQ;
                    end
                end
            end
            ST_L2_REQ: begin
                if (mem_req_ready) d.st = ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    d.leaf   = mem_rdata;
                    d.status = leaf_status;
                    if (leaf_status == WALK_OK) begin
                        d.paddr = {mem_rdata[PA_W-1:OFF_W], q.vaddr[OFF_W-1:0]};
                        d.st    = leaf_need_dirty ? ST_WB_REQ : ST_RESP;
                    end else begin
                        d.paddr = '0;
                        d.st    = ST_RESP;
                    end
                end
            end
            ST_WB_REQ: begin
                if (mem_req_ready) d.st = ST_RESP;
            end
            ST_RESP: begin
                if (rsp_ready) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready     = (q.st == ST_IDLE);
        rsp_valid     = (q.st == ST_RESP);
        rsp_paddr     = q.paddr;
        rsp_status    = q.status;
        mem_req_valid = (q.st == ST_L1_REQ) || (q.st == ST_L2_REQ) || (q.st == ST_WB_REQ);
        mem_we        = (q.st == ST_WB_REQ);
        mem_addr      = (q.st == ST_L1_REQ) ? l1_addr : l2_addr;
        mem_wdata     = q.leaf | (PA_W'(1) << D_BIT);
    end

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_status)); // R1

    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R1

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_we)); // R11

    AST_WB_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_we |-> mem_wdata[D_BIT] && mem_wdata[P_BIT] && mem_wdata[W_BIT]); // R9

    AST_WB_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_we |-> q.is_write); // R10

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status == WALK_OK |-> rsp_paddr[OFF_W-1:0] == q.vaddr[OFF_W-1:0]); // R8

    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status != WALK_OK |-> rsp_paddr == '0); // R4
endmodule

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = 32'h0001_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_status;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    ptw_top u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .root_base     (root_base),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .req_user      (req_user),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_status    (rsp_status),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rdata     (mem_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    // memory model
    logic [31:0] mem [logic [31:0]];
    int          rd_lat = 1;
    int          ready_period = 1;
    int          cyc = 0;
    int          pend = 0;
    logic [31:0] pend_addr = '0;
    int          acc_n = 0;
    logic [31:0] acc_addr [16];
    logic        acc_we [16];
    logic [31:0] acc_data [16];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rdata     = rd(pend_addr);
            end
        end
        mem_req_ready = ((cyc % ready_period) == 0);
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (acc_n < 16) begin
                acc_addr[acc_n] = mem_addr;
                acc_we[acc_n]   = mem_we;
                acc_data[acc_n] = mem_wdata;
            end
            acc_n++;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else begin
                pend      = rd_lat;
                pend_addr = mem_addr;
            end
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    logic [31:0] got_pa;
    logic [1:0]  got_st;

    // one walk; hold > 0 keeps rsp_ready low and req_valid high for that many cycles
    task automatic walk(input logic [31:0] va, input logic wr, input logic usr, input int hold);
        int guard;
        @(negedge clk);
        acc_n     = 0;
        req_vaddr = va;
        req_write = wr;
        req_user  = usr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        got_pa = rsp_paddr;
        got_st = rsp_status;
        if (hold > 0) begin
            req_valid = 1'b1;
            req_vaddr = 32'hDEAD_B000;
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                check("R1 rsp_valid held", 32'(rsp_valid), 32'h1);
                check("R1 rsp_paddr held", rsp_paddr, got_pa);
                check("R1 req_ready low while busy", 32'(req_ready), 32'h0);
            end
            req_valid = 1'b0;
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R1 back to idle", 32'(req_ready), 32'h1);
    endtask

    task automatic t_reset();
        check("R1 reset req_ready", 32'(req_ready), 32'h1);
        check("R1 reset rsp_valid", 32'(rsp_valid), 32'h0);
        check("R1 reset mem_req_valid", 32'(mem_req_valid), 32'h0);
    endtask

    task automatic t_read_ok();
        walk(32'h0040_3ABC, 1'b0, 1'b1, 0);
        check("R2 L1 address", acc_addr[0], 32'h0001_0004);
        check("R3 L2 address", acc_addr[1], 32'h0002_000C);
        check("R8 paddr", got_pa, 32'h1234_5ABC);
        check("R8 status ok", 32'(got_st), 32'h0);
        check("R10 no write on read", 32'(acc_n), 32'd2);
    endtask

    task automatic t_dirty_write();
        walk(32'h0040_5010, 1'b1, 1'b1, 0);
        check("R9 access count", 32'(acc_n), 32'd3);
        check("R9 write flag", 32'(acc_we[2]), 32'h1);
        check("R9 write address", acc_addr[2], 32'h0002_0014);
        check("R9 write data", acc_data[2], 32'h0AAA_A047);
        check("R9 status ok", 32'(got_st), 32'h0);
        check("R8 paddr write", got_pa, 32'h0AAA_A010);
        walk(32'h0040_5010, 1'b1, 1'b1, 0);
        check("R10 no second write-back", 32'(acc_n), 32'd2);
        check("R10 status ok", 32'(got_st), 32'h0);
    endtask

    task automatic t_l1_not_present();
        walk(32'h0080_0123, 1'b0, 1'b0, 0);
        check("R4 single read", 32'(acc_n), 32'd1);
        check("R4 L1 address", acc_addr[0], 32'h0001_0008);
        check("R4 status", 32'(got_st), 32'h1);
        check("R4 paddr zero", got_pa, 32'h0);
    endtask

    task automatic t_l2_not_present();
        walk(32'h0040_6000, 1'b1, 1'b1, 0);
        check("R5 status", 32'(got_st), 32'h1);
        check("R5 no write", 32'(acc_n), 32'd2);
    endtask

    task automatic t_protect_write();
        walk(32'h0040_7000, 1'b1, 1'b0, 0);
        check("R6 status", 32'(got_st), 32'h2);
        check("R6 no write", 32'(acc_n), 32'd2);
        check("R6 paddr zero", got_pa, 32'h0);
    endtask

    task automatic t_user();
        walk(32'h0040_8000, 1'b0, 1'b1, 0);
        check("R7 user blocked", 32'(got_st), 32'h2);
        walk(32'h0040_8000, 1'b0, 1'b0, 0);
        check("R7 supervisor ok", 32'(got_st), 32'h0);
        check("R7 supervisor paddr", got_pa, 32'h0DDD_D000);
    endtask

    task automatic t_last_index();
        walk(32'hFFFF_FFFF, 1'b0, 1'b0, 0);
        check("R2 last L1 index", acc_addr[0], 32'h0001_0FFC);
        check("R3 last L2 index", acc_addr[1], 32'h0004_0FFC);
        check("R8 last paddr", got_pa, 32'h0EEE_EFFF);
    endtask

    task automatic t_stall();
        ready_period = 3;
        rd_lat       = 4;
        walk(32'h0040_3ABC, 1'b0, 1'b1, 3);
        check("R11 L1 address stalled", acc_addr[0], 32'h0001_0004);
        check("R11 L2 address stalled", acc_addr[1], 32'h0002_000C);
        check("R11 paddr stalled", got_pa, 32'h1234_5ABC);
        mem[32'h0002_0014] = 32'h0AAA_A007;
        walk(32'h0040_5010, 1'b1, 1'b0, 0);
        check("R11 write-back stalled", acc_data[2], 32'h0AAA_A047);
        check("R11 access count", 32'(acc_n), 32'd3);
        ready_period = 1;
        rd_lat       = 1;
    endtask

    initial begin
        mem[32'h0001_0004] = 32'h0002_0001;
        mem[32'h0002_000C] = 32'h1234_5007;
        mem[32'h0002_0014] = 32'h0AAA_A007;
        mem[32'h0001_0008] = 32'h0003_0000;
        mem[32'h0002_0018] = 32'h0BBB_B006;
        mem[32'h0002_001C] = 32'h0CCC_C005;
        mem[32'h0002_0020] = 32'h0DDD_D003;
        mem[32'h0001_0FFC] = 32'h0004_0001;
        mem[32'h0004_0FFC] = 32'h0EEE_E0C1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_ok();
        t_dirty_write();
        t_l1_not_present();
        t_l2_not_present();
        t_protect_write();
        t_user();
        t_last_index();
        t_stall();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule